// File: doc/BRIEF.md
# Platform System Control Register File

This block is a small bank of byte-wide board control and identification registers that a processor reaches through an ISA-style I/O cycle: one address, a write strobe, a read strobe and an eight-bit data path. A window of 0x52 byte addresses starting at 0x0800 holds the registers. A lone extra port at 0x0092 gives the soft-reset control. Reads are registered, so the byte appears on `rdData` one clock after the read strobe and stays there until the next read.

Some of the registers are fixed identification bytes for the processor and the board. One returns a constant meaning that no second-level cache is fitted. The rest hold state that other logic uses: a reset request for the processor, a drive-activity light flag, a four-bit system control field, and the bit that picks between the contiguous and the sparse I/O map of the address translator. A write to either of two password-protect offsets sends a one-cycle toggle pulse to the nonvolatile memory lock that belongs to it. Any offset that nothing decodes reads as 0xFF and ignores writes.

Top module: `sysctl_regs`

## Requirements
- R1: While `rstN` is low and after it rises, `resetReq`, `lightOn`, `lockPulse`, `mapSparse` and `rdData` are all 0, and the system control field is 0.
- R2: A write to address 0x0092 sets `resetReq` to data bit 0 from the next clock on. A read of 0x0092 returns 0x00 or 0x01, following `resetReq`.
- R3: Reads of window offsets 0x00, 0x01, 0x02 and 0x03 return the fixed bytes 0xEF, 0xAD, 0xE0 and 0x39. Writes there change nothing.
- R4: A read of offset 0x15 returns 0x03.
- R5: A write to offset 0x14 keeps only data bits 3:0. A read of 0x14 returns those bits with bits 7:4 at zero.
- R6: A write to offset 0x50 keeps only data bit 0 and drives it on `mapSparse` from the next clock on. A read of 0x50 returns 0x00 or 0x01.
- R7: A write to offset 0x08 sets `lightOn` to data bit 0. A read of 0x08 returns 0x00 or 0x01, following `lightOn`.
- R8: A write to offset 0x10 sets `lockPulse[0]` high, and a write to 0x11 sets `lockPulse[1]` high, for exactly the one cycle after the write clock. Reads of these offsets return 0xFF.
- R9: Every undecoded window offset (0x12 among them) and every address outside both the window and 0x0092 reads 0xFF. Writes to any of them leave all state and outputs unchanged.
- R10: `rdData` loads on a clock edge where `ioRd` is high and holds its value on every other clock. A write in the same cycle as a read of the same register does not show in that read's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 16 | I/O byte address |
| ioWr | input | 1 | Write strobe, one cycle per write |
| ioRd | input | 1 | Read strobe, one cycle per read |
| ioWdata | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| resetReq | output | 1 | Processor reset request |
| lightOn | output | 1 | Drive-activity light flag |
| lockPulse | output | 2 | One-cycle lock-toggle pulses, bit 0 for lock 1 and bit 1 for lock 2 |
| mapSparse | output | 1 | I/O map type select, 1 for the sparse map |

## Verification
The hardest case to reach is a read and a write to the same register in the same cycle. The read has to return the value from before the write, while the output already shows the new one on the next clock. The stimulus produces this on purpose by holding `ioRd` and `ioWr` high together on the light, map, system control and reset-port addresses. It also issues back-to-back writes to the lock offsets, so that adjacent pulses must not merge or spill into the other lock. A random phase mixes addresses from the window edges (0x07FF, 0x0851, 0x0852) with every decoded offset, and a behavioural model checks every output on every clock.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 16;
  localparam int NUM_LOCKS = 2;

  localparam logic [ADDR_W-1:0] OFF_CPUCFG  = 16'h0000;
  localparam logic [ADDR_W-1:0] OFF_FEAT    = 16'h0001;
  localparam logic [ADDR_W-1:0] OFF_STAT    = 16'h0002;
  localparam logic [ADDR_W-1:0] OFF_EXTFEAT = 16'h0003;
  localparam logic [ADDR_W-1:0] OFF_LIGHT   = 16'h0008;
  localparam logic [ADDR_W-1:0] OFF_LOCK0   = 16'h0010;
  localparam logic [ADDR_W-1:0] OFF_SYSCTL  = 16'h0014;
  localparam logic [ADDR_W-1:0] OFF_CACHE   = 16'h0015;
  localparam logic [ADDR_W-1:0] OFF_MAP     = 16'h0050;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CPUCFG, SEL_FEAT, SEL_STAT, SEL_EXTFEAT,
    SEL_PORT, SEL_LIGHT, SEL_SYSCTL, SEL_CACHE, SEL_MAP
  } rdSel_e;

  typedef struct packed {
    logic                 wrPort;
    logic                 wrLight;
    logic [NUM_LOCKS-1:0] wrLock;
    logic                 wrSysCtl;
    logic                 wrMap;
    logic                 rdEn;
    rdSel_e               rdSel;
  } strobes_t;

endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter logic [ADDR_W-1:0] WIN_BASE  = 16'h0800,
  parameter logic [ADDR_W-1:0] WIN_SIZE  = 16'h0052,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0092
) (
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [ADDR_W-1:0] ioAddr,
  output strobes_t          strb
);

  localparam logic [ADDR_W-1:0] WIN_END = WIN_BASE + WIN_SIZE;

  logic              inWin;
  logic              isPort;
  logic [ADDR_W-1:0] off;
  rdSel_e            sel;
  logic [NUM_LOCKS-1:0] lockHit;

  assign inWin  = (ioAddr >= WIN_BASE) && (ioAddr < WIN_END);
  assign isPort = (ioAddr == PORT_ADDR);
  assign off    = ioAddr - WIN_BASE;

  for (genvar i = 0; i < NUM_LOCKS; i++) begin : gLockDec
    assign lockHit[i] = inWin && (off == OFF_LOCK0 + ADDR_W'(i));
  end

  always_comb begin
    sel = SEL_NONE;
    if (isPort) begin
      sel = SEL_PORT;
    end else if (inWin) begin
      case (off)
        OFF_CPUCFG:  sel = SEL_CPUCFG;
        OFF_FEAT:    sel = SEL_FEAT;
        OFF_STAT:    sel = SEL_STAT;
        OFF_EXTFEAT: sel = SEL_EXTFEAT;
        OFF_LIGHT:   sel = SEL_LIGHT;
        OFF_SYSCTL:  sel = SEL_SYSCTL;
        OFF_CACHE:   sel = SEL_CACHE;
        OFF_MAP:     sel = SEL_MAP;
        default:     sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.rdEn     = ioRd;
    strb.rdSel    = sel;
    strb.wrPort   = ioWr && (sel == SEL_PORT);
    strb.wrLight  = ioWr && (sel == SEL_LIGHT);
    strb.wrSysCtl = ioWr && (sel == SEL_SYSCTL);
    strb.wrMap    = ioWr && (sel == SEL_MAP);
    strb.wrLock   = ioWr ? lockHit : '0;
  end

  always_comb begin
    AST_ONE_WRITE_TARGET: assert ($countones({strb.wrPort, strb.wrLight, strb.wrLock,
                                              strb.wrSysCtl, strb.wrMap}) <= 1); // R9
  end

endmodule

// File: rtl/sysctl_dp.sv
module sysctl_dp
  import sysctl_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_CPUCFG  = 8'hEF,
  parameter logic [DATA_W-1:0] ID_FEAT    = 8'hAD,
  parameter logic [DATA_W-1:0] ID_STAT    = 8'hE0,
  parameter logic [DATA_W-1:0] ID_EXTFEAT = 8'h39,
  parameter logic [DATA_W-1:0] ID_CACHE   = 8'h03
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             strb,
  input  logic [DATA_W-1:0]    ioWdata,
  output logic [DATA_W-1:0]    rdData,
  output logic                 resetReq,
  output logic                 lightOn,
  output logic [NUM_LOCKS-1:0] lockPulse,
  output logic                 mapSparse
);

  localparam logic [DATA_W-1:0] BIT0_MASK   = DATA_W'(1);
  localparam logic [DATA_W-1:0] SYSCTL_MASK = DATA_W'(4'hF);
  localparam logic [DATA_W-1:0] UNIMPL      = '1;

  logic [DATA_W-1:0] portReg, lightReg, sysReg, mapReg, rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portReg  <= '0;
      lightReg <= '0;
      sysReg   <= '0;
      mapReg   <= '0;
    end else begin
      if (strb.wrPort)   portReg  <= ioWdata & BIT0_MASK;
      if (strb.wrLight)  lightReg <= ioWdata & BIT0_MASK;
      if (strb.wrSysCtl) sysReg   <= ioWdata & SYSCTL_MASK;
      if (strb.wrMap)    mapReg   <= ioWdata & BIT0_MASK;
    end
  end

  for (genvar i = 0; i < NUM_LOCKS; i++) begin : gLockPulse
    always_ff @(posedge clk) begin
      if (!rstN) lockPulse[i] <= 1'b0;
      else       lockPulse[i] <= strb.wrLock[i];
    end
  end

  always_comb begin
    case (strb.rdSel)
      SEL_CPUCFG:  rdNext = ID_CPUCFG;
      SEL_FEAT:    rdNext = ID_FEAT;
      SEL_STAT:    rdNext = ID_STAT;
      SEL_EXTFEAT: rdNext = ID_EXTFEAT;
      SEL_CACHE:   rdNext = ID_CACHE;
      SEL_PORT:    rdNext = portReg;
      SEL_LIGHT:   rdNext = lightReg;
      SEL_SYSCTL:  rdNext = sysReg;
      SEL_MAP:     rdNext = mapReg;
      default:     rdNext = UNIMPL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdEn) rdData <= rdNext;
  end

  assign resetReq  = portReg[0];
  assign lightOn   = lightReg[0];
  assign mapSparse = mapReg[0];

  AST_PORT_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrPort |=> (resetReq == $past(ioWdata[0]))); // R2
  AST_SYSCTL_NIBBLE: assert property (@(posedge clk) disable iff (!rstN)
    sysReg[DATA_W-1:4] == '0); // R5
  AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrMap |=> $stable(mapSparse)); // R6
  AST_LIGHT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrLight |=> $stable(lightOn)); // R7
  AST_LOCK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lockPulse)); // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> $stable(rdData)); // R10

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter logic [15:0] WIN_BASE  = 16'h0800,
  parameter logic [15:0] WIN_SIZE  = 16'h0052,
  parameter logic [15:0] PORT_ADDR = 16'h0092
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [15:0] ioAddr,
  input  logic       ioWr,
  input  logic       ioRd,
  input  logic [7:0] ioWdata,
  output logic [7:0] rdData,
  output logic       resetReq,
  output logic       lightOn,
  output logic [1:0] lockPulse,
  output logic       mapSparse
);

  strobes_t strb;

  sysctl_ctrl #(
    .WIN_BASE (WIN_BASE),
    .WIN_SIZE (WIN_SIZE),
    .PORT_ADDR(PORT_ADDR)
  ) u_ctrl (
    .ioWr  (ioWr),
    .ioRd  (ioRd),
    .ioAddr(ioAddr),
    .strb  (strb)
  );

  sysctl_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .ioWdata  (ioWdata),
    .rdData   (rdData),
    .resetReq (resetReq),
    .lightOn  (lightOn),
    .lockPulse(lockPulse),
    .mapSparse(mapSparse)
  );

  AST_LOCK1_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    lockPulse[0] |-> $past(ioWr && (ioAddr == WIN_BASE + 16'h0010))); // R8
  AST_UNMAPPED_FF: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && (ioAddr != PORT_ADDR) && ((ioAddr < WIN_BASE) || (ioAddr >= WIN_BASE + WIN_SIZE)))
      |=> (rdData == 8'hFF)); // R9
  AST_CPUCFG_READ: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && (ioAddr == WIN_BASE)) |=> (rdData == 8'hEF)); // R3

endmodule

// File: tb/sysctl_regs_tb.sv
module sysctl_regs_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ioAddr = '0;
  logic        ioWr = 1'b0;
  logic        ioRd = 1'b0;
  logic [7:0]  ioWdata = '0;
  logic [7:0]  rdData;
  logic        resetReq, lightOn, mapSparse;
  logic [1:0]  lockPulse;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  // Reference model state
  int mPort = 0, mLight = 0, mSys = 0, mMap = 0, mRd = 0, mLock = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_regs u_dut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .ioWdata(ioWdata), .rdData(rdData), .resetReq(resetReq), .lightOn(lightOn),
    .lockPulse(lockPulse), .mapSparse(mapSparse)
  );

  function automatic int readVal(int a);
    case (a)
      'h0092: return mPort;
      'h0800: return 'hEF;
      'h0801: return 'hAD;
      'h0802: return 'hE0;
      'h0803: return 'h39;
      'h0808: return mLight;
      'h0814: return mSys;
      'h0815: return 'h03;
      'h0850: return mMap;
      default: return 'hFF;
    endcase
  endfunction

  function automatic string reqOf(int a);
    case (a)
      'h0092: return "R2";
      'h0800, 'h0801, 'h0802, 'h0803: return "R3";
      'h0815: return "R4";
      'h0814: return "R5";
      'h0850: return "R6";
      'h0808: return "R7";
      'h0810, 'h0811: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic compareAll(string rdReq);
    check("R2", "resetReq", int'(resetReq), mPort);
    check("R7", "lightOn", int'(lightOn), mLight);
    check("R8", "lockPulse", int'(lockPulse), mLock);
    check("R6", "mapSparse", int'(mapSparse), mMap);
    check(rdReq, "rdData (R10 timing)", int'(rdData), mRd);
  endtask

  // One bus cycle: drive at negedge, clock, update model, compare at next negedge
  task automatic cyc(bit wr, bit rd, int a, int d);
    string rq;
    ioWr = wr; ioRd = rd; ioAddr = 16'(a); ioWdata = 8'(d);
    @(posedge clk);
    @(negedge clk);
    rq = rd ? reqOf(a) : "R10";
    if (rd) mRd = readVal(a);       // read sees state before same-cycle write
    mLock = 0;
    if (wr) begin
      case (a)
        'h0092: mPort  = d & 1;
        'h0808: mLight = d & 1;
        'h0814: mSys   = d & 'hF;
        'h0850: mMap   = d & 1;
        'h0810: mLock  = 1;
        'h0811: mLock  = 2;
        default: ;
      endcase
    end
    ioWr = 0; ioRd = 0;
    compareAll(rq);
  endtask

  task automatic wr(int a, int d); cyc(1, 0, a, d); endtask
  task automatic rd(int a);        cyc(0, 1, a, 0); endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES && !finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG_CYCLES);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  initial begin
    int addrs[17] = '{'h0092, 'h0800, 'h0801, 'h0802, 'h0803, 'h0808, 'h0810, 'h0811,
                      'h0812, 'h0814, 'h0815, 'h0850, 'h0851, 'h0852, 'h07FF, 'h0004, 'h0093};
    // R1: reset state, with strobes driven during reset
    ioWr = 1; ioAddr = 16'h0092; ioWdata = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compareAll("R1");
    ioWr = 0;
    rstN = 1;
    @(negedge clk);
    compareAll("R1");
    rd('h0814); // R1: system control field clear after reset

    // R3, R4: identification bytes and cache status
    rd('h0800); rd('h0801); rd('h0802); rd('h0803); rd('h0815);
    wr('h0800, 'h00); wr('h0803, 'h00); rd('h0800); rd('h0803);

    // R2: soft-reset port set, read, clear
    wr('h0092, 'h01); rd('h0092); wr('h0092, 'hFE); rd('h0092);
    // R5: low nibble only
    wr('h0814, 'hA7); rd('h0814); wr('h0814, 'hF0); rd('h0814);
    // R6: map bit
    wr('h0850, 'hFF); rd('h0850); wr('h0850, 'h02); rd('h0850);
    // R7: light flag
    wr('h0808, 'h03); rd('h0808); wr('h0808, 'h00);
    // R8: lock pulses, back to back and alternating
    wr('h0810, 'h5A); wr('h0810, 'h00); wr('h0811, 'h00); rd('h0810); rd('h0811);
    // R9: undecoded offsets and outside addresses
    wr('h0092, 1); wr('h0808, 1); wr('h0850, 1); wr('h0814, 5);
    wr('h0812, 0); wr('h0851, 0); wr('h0852, 0); wr('h07FF, 0); wr('h0093, 0);
    rd('h0812); rd('h0851); rd('h0852); rd('h07FF); rd('h0004);
    // R10: read and write same register same cycle; hold without read
    cyc(1, 1, 'h0808, 0); rd('h0808);
    cyc(1, 1, 'h0850, 0); cyc(1, 1, 'h0814, 'hC); cyc(1, 1, 'h0092, 0);
    cyc(0, 0, 'h0800, 0); cyc(1, 0, 'h0815, 0);

    // Random mix over decoded offsets and window edges
    for (int i = 0; i < 600; i++) begin
      int a = addrs[$urandom_range(0, 16)];
      cyc(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), a, int'($urandom_range(0, 255)));
    end

    // Reset mid-run clears state again (R1)
    rstN = 0;
    @(posedge clk); @(negedge clk);
    mPort = 0; mLight = 0; mSys = 0; mMap = 0; mRd = 0; mLock = 0;
    compareAll("R1");
    rstN = 1;
    rd('h0814);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

endmodule